// File: doc/BRIEF.md
# Serial Command and Register Read Slave

This block sits behind the serial control port of a power-converter controller. An external host runs a four-wire serial link in mode 3: the clock idles high, both sides change their data lines on falling edges and sample on rising edges, and every byte travels most significant bit first. Each frame opens with a command byte. A command can fire a shutdown or turn-on strobe into the converter, or it can select one of four registers to be returned to the host: the current sample, the input-voltage sample, the PWM duty or the status word.

For a read, the block takes a snapshot of the selected register when the last bit of the command arrives. It then shifts the snapshot out on MISO while the host clocks in 0x00 filler bytes, one data byte for each byte received. Values wider than a byte are zero-extended and right-justified, and the upper byte goes first. All sampling is done in the system clock domain. SCLK, MOSI and the active-low select pass through a synchroniser, and edges are found by comparing the synchronised clock with its previous value. The serial clock must therefore be well below the system clock.

Top module: `spiRegReadSlave`

## Requirements
- R1: After reset, MISO is 0 and both command strobes are low.
- R2: MISO changes only after a falling edge of SCLK (or when select is released). It holds steady while SCLK is high, and MOSI is taken on rising edges.
- R3: Every byte is received and sent most significant bit first.
- R4: Command 0x04 returns the 10-bit current sample as two bytes: first {6'b0, value[9:8]}, then value[7:0].
- R5: Command 0x05 returns the 10-bit input-voltage sample in the same two-byte right-justified form.
- R6: Command 0x06 returns the 9-bit PWM duty as {7'b0, value[8]} followed by value[7:0].
- R7: Command 0x07 returns one byte {1'b0, status[6:0]}. In the status field, bits 6..3 are per-phase overcurrent, bit 2 is overvoltage, bit 1 is overtemperature and bit 0 is a spare flag.
- R8: The register being read is captured when the command byte completes. Later changes to the input do not alter the bytes still to be sent.
- R9: MISO carries 0 while a command byte shifts in, for all bytes after commands 0x00, 0x01 and codes above 0x07, and while select is high.
- R10: A complete command byte 0x02 gives exactly one system-clock pulse on the shutdown strobe. A complete 0x03 gives exactly one pulse on the turn-on strobe.
- R11: If select rises before a command byte is complete, its bits are discarded and nothing is triggered. The next low period of select starts with a fresh command byte.
- R12: Bytes inside a frame may be separated by a pause of any length, or may follow each other with no gap.
- R13: Once the last data byte of a read has been sent, the next byte in the same frame is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| mosi | input | 1 | Serial data from the host |
| ssN | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the host |
| curSample | input | CUR_W | Current sample register |
| vinSample | input | VIN_W | Input-voltage sample register |
| pwmDuty | input | PWM_W | PWM duty register |
| statusWord | input | STAT_W | Status flags |
| shutdownStb | output | 1 | One-cycle shutdown request |
| turnOnStb | output | 1 | One-cycle turn-on request |

## Verification
The bench uses asymmetric values such as 0x2A5 and 0x155. A design that reversed the bit order or placed the upper bits in the wrong byte would return scrambled bytes rather than a plausible value. It changes the current sample between the command byte and the data bytes, so a design without a snapshot returns mixed data. It drops select partway through a command and then issues a read. Leftover bits would misalign that command and return zeros or the wrong register. It chains a second read after a first one inside a single frame and inserts long pauses between bytes. These cases expose a byte counter that fails to return to command decoding, or that depends on back-to-back clocking.

// File: rtl/spiRdPkg.sv
package spiRdPkg;
  localparam logic [7:0] CMD_SHUT     = 8'h02;
  localparam logic [7:0] CMD_ON       = 8'h03;
  localparam logic [7:0] CMD_RD_CUR   = 8'h04;
  localparam logic [7:0] CMD_RD_VIN   = 8'h05;
  localparam logic [7:0] CMD_RD_PWM   = 8'h06;
  localparam logic [7:0] CMD_RD_STAT  = 8'h07;
  localparam int         PAD_W        = 16;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic       frameClr;
    logic       sampleBit;
    logic       launchBit;
    logic       byteDone;
    logic [2:0] bitIdx;
    logic       mosiBit;
  } spiStb_t;
endpackage

// File: rtl/spiRdTiming.sv
module spiRdTiming
  import spiRdPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sclk,
  input  logic    mosi,
  input  logic    ssN,
  output spiStb_t stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclkPipe, ssPipe, mosiPipe;
  logic          sclkPrev;
  logic [2:0]    bitIdx;
  logic          sclkS, ssS, riseEv, fallEv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclkPipe <= '1;
      ssPipe   <= '1;
      mosiPipe <= '0;
      sclkPrev <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[LAST-1:0], sclk};
      ssPipe   <= {ssPipe[LAST-1:0], ssN};
      mosiPipe <= {mosiPipe[LAST-1:0], mosi};
      sclkPrev <= sclkPipe[LAST];
    end
  end

  assign sclkS  = sclkPipe[LAST];
  assign ssS    = ssPipe[LAST];
  assign riseEv = sclkS & ~sclkPrev & ~ssS;
  assign fallEv = ~sclkS & sclkPrev & ~ssS;

  always_ff @(posedge clk) begin
    if (!rst_n || ssS) bitIdx <= '0;
    else if (riseEv)   bitIdx <= bitIdx + 3'd1;
  end

  always_comb begin
    stb.frameClr  = ssS;
    stb.sampleBit = riseEv;
    stb.launchBit = fallEv;
    stb.byteDone  = riseEv && (bitIdx == 3'd7);
    stb.bitIdx    = bitIdx;
    stb.mosiBit   = mosiPipe[LAST];
  end
endmodule

// File: rtl/spiRdData.sv
module spiRdData
  import spiRdPkg::*;
#(
  parameter int CUR_W  = 10,
  parameter int VIN_W  = 10,
  parameter int PWM_W  = 9,
  parameter int STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spiStb_t           stb,
  input  logic [CUR_W-1:0]  curSample,
  input  logic [VIN_W-1:0]  vinSample,
  input  logic [PWM_W-1:0]  pwmDuty,
  input  logic [STAT_W-1:0] statusWord,
  output logic              miso,
  output logic              shutdownStb,
  output logic              turnOnStb
);
  localparam int CUR_NB  = (CUR_W + 7) / 8;
  localparam int VIN_NB  = (VIN_W + 7) / 8;
  localparam int PWM_NB  = (PWM_W + 7) / 8;
  localparam int STAT_NB = (STAT_W + 7) / 8;

  logic [6:0]       rxShift;
  logic [7:0]       rxByte, txByte, snapLo;
  logic             inCmd;
  logic [1:0]       bytesLeft;
  logic [PAD_W-1:0] curPad, vinPad, pwmPad, statPad;

  assign rxByte  = {rxShift, stb.mosiBit};
  assign curPad  = PAD_W'(curSample);
  assign vinPad  = PAD_W'(vinSample);
  assign pwmPad  = PAD_W'(pwmDuty);
  assign statPad = PAD_W'(statusWord);

  function automatic logic [7:0] headByte(logic [PAD_W-1:0] p, int nb);
    return (nb == 2) ? p[15:8] : p[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0; txByte <= '0; snapLo <= '0; inCmd <= 1'b1;
      bytesLeft <= '0; miso <= 1'b0; shutdownStb <= 1'b0; turnOnStb <= 1'b0;
    end else begin
      shutdownStb <= 1'b0;
      turnOnStb   <= 1'b0;
      if (stb.frameClr) begin
        rxShift <= '0; txByte <= '0; inCmd <= 1'b1; bytesLeft <= '0; miso <= 1'b0;
      end else begin
        if (stb.sampleBit) rxShift <= rxByte[6:0];
        if (stb.launchBit) miso <= txByte[3'd7 - stb.bitIdx];
        if (stb.byteDone) begin
          if (inCmd) begin
            txByte <= '0;
            case (rxByte)
              CMD_SHUT: shutdownStb <= 1'b1;
              CMD_ON:   turnOnStb   <= 1'b1;
              CMD_RD_CUR: begin
                txByte <= headByte(curPad, CUR_NB); snapLo <= curPad[7:0];
                bytesLeft <= 2'(CUR_NB); inCmd <= 1'b0;
              end
              CMD_RD_VIN: begin
                txByte <= headByte(vinPad, VIN_NB); snapLo <= vinPad[7:0];
                bytesLeft <= 2'(VIN_NB); inCmd <= 1'b0;
              end
              CMD_RD_PWM: begin
                txByte <= headByte(pwmPad, PWM_NB); snapLo <= pwmPad[7:0];
                bytesLeft <= 2'(PWM_NB); inCmd <= 1'b0;
              end
              CMD_RD_STAT: begin
                txByte <= headByte(statPad, STAT_NB); snapLo <= statPad[7:0];
                bytesLeft <= 2'(STAT_NB); inCmd <= 1'b0;
              end
              default: ;
            endcase
          end else if (bytesLeft == 2'd2) begin
            txByte    <= snapLo;
            bytesLeft <= 2'd1;
          end else begin
            txByte    <= '0;
            bytesLeft <= '0;
            inCmd     <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spiRegReadSlave.sv
module spiRegReadSlave
  import spiRdPkg::*;
#(
  parameter int CUR_W       = 10,
  parameter int VIN_W       = 10,
  parameter int PWM_W       = 9,
  parameter int STAT_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              ssN,
  output logic              miso,
  input  logic [CUR_W-1:0]  curSample,
  input  logic [VIN_W-1:0]  vinSample,
  input  logic [PWM_W-1:0]  pwmDuty,
  input  logic [STAT_W-1:0] statusWord,
  output logic              shutdownStb,
  output logic              turnOnStb
);
  spiStb_t stb;

  spiRdTiming #(.SYNC_STAGES(SYNC_STAGES)) u_timing (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ssN(ssN), .stb(stb)
  );

  spiRdData #(.CUR_W(CUR_W), .VIN_W(VIN_W), .PWM_W(PWM_W), .STAT_W(STAT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .curSample(curSample), .vinSample(vinSample), .pwmDuty(pwmDuty),
    .statusWord(statusWord), .miso(miso),
    .shutdownStb(shutdownStb), .turnOnStb(turnOnStb)
  );
endmodule

// File: rtl/spiRegReadSlave_chk.sv
module spiRegReadSlave_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic ssN,
  input logic miso,
  input logic shutdownStb,
  input logic turnOnStb
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdownStb && turnOnStb)); // R10
  AST_SHUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdownStb |=> !shutdownStb); // R10
  AST_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    turnOnStb |=> !turnOnStb); // R10
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ssN && $past(ssN) && $past(ssN, 2) && $past(ssN, 3)) |-> !miso); // R9
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && $past(sclk, 2) && $past(sclk, 3) && $past(sclk, 4)
     && $past(sclk, 5) && !ssN && !$past(ssN) && !$past(ssN, 2) && !$past(ssN, 3)
     && !$past(ssN, 4) && !$past(ssN, 5)) |-> $stable(miso)); // R2
endmodule

bind spiRegReadSlave spiRegReadSlave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ssN(ssN), .miso(miso),
  .shutdownStb(shutdownStb), .turnOnStb(turnOnStb)
);

// File: tb/spiRegReadSlave_tb.sv
module spiRegReadSlave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NVEC       = 11;
  // {cmd, cur, vin, pwm, stat, exp0, exp1, nbytes, pad}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'h04, 10'h3FF, 10'h000, 9'h000, 7'h00, 8'h03, 8'hFF, 2'd2, 2'd0},
    {8'h04, 10'h2A5, 10'h111, 9'h011, 7'h11, 8'h02, 8'hA5, 2'd2, 2'd0},
    {8'h05, 10'h0F0, 10'h155, 9'h000, 7'h00, 8'h01, 8'h55, 2'd2, 2'd0},
    {8'h05, 10'h3FF, 10'h000, 9'h1FF, 7'h7F, 8'h00, 8'h00, 2'd2, 2'd0},
    {8'h06, 10'h000, 10'h000, 9'h1FF, 7'h00, 8'h01, 8'hFF, 2'd2, 2'd0},
    {8'h06, 10'h3FF, 10'h3FF, 9'h0C3, 7'h00, 8'h00, 8'hC3, 2'd2, 2'd0},
    {8'h07, 10'h000, 10'h000, 9'h000, 7'h55, 8'h55, 8'h00, 2'd1, 2'd0},
    {8'h07, 10'h3FF, 10'h3FF, 9'h1FF, 7'h7F, 8'h7F, 8'h00, 2'd1, 2'd0},
    {8'h01, 10'h3FF, 10'h3FF, 9'h1FF, 7'h7F, 8'h00, 8'h00, 2'd1, 2'd0},
    {8'h00, 10'h3FF, 10'h3FF, 9'h1FF, 7'h7F, 8'h00, 8'h00, 2'd1, 2'd0},
    {8'h09, 10'h3FF, 10'h3FF, 9'h1FF, 7'h7F, 8'h00, 8'h00, 2'd1, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, mosi = 1'b0, ssN = 1'b1;
  logic miso, shutdownStb, turnOnStb;
  logic [9:0] curSample = '0, vinSample = '0;
  logic [8:0] pwmDuty = '0;
  logic [6:0] statusWord = '0;
  int total = 0, bad = 0, highMoves = 0;
  int shutHigh = 0, onHigh = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spiRegReadSlave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ssN(ssN), .miso(miso),
    .curSample(curSample), .vinSample(vinSample), .pwmDuty(pwmDuty),
    .statusWord(statusWord), .shutdownStb(shutdownStb), .turnOnStb(turnOnStb)
  );

  always @(posedge clk) begin
    if (shutdownStb) shutHigh <= shutHigh + 1;
    if (turnOnStb)   onHigh   <= onHigh + 1;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    logic m1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      waitClk(2);
      m1 = miso;
      waitClk(HALF - 2);
      if (miso !== m1) highMoves++;
    end
  endtask

  task automatic frameOpen();
    ssN = 1'b0; waitClk(HALF);
  endtask

  task automatic frameClose();
    waitClk(HALF); ssN = 1'b1; waitClk(2 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, rc;
    int s0, o0;
    waitClk(5);
    chk("R1", "miso in reset", 16'(miso), 16'h0);
    chk("R1", "strobes in reset", {14'b0, shutdownStb, turnOnStb}, 16'h0);
    rst_n = 1'b1;
    waitClk(4);
    chk("R1", "miso after reset", 16'(miso), 16'h0);

    // vector table: reads and non-read commands (R3..R7, R9)
    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] e;
      e = VEC[v];
      curSample = e[55:46]; vinSample = e[45:36]; pwmDuty = e[35:27]; statusWord = e[26:20];
      frameOpen();
      xferByte(e[63:56], rc);
      chk("R9", "miso during command byte", 16'(rc), 16'h0);
      waitClk(v * 3);
      xferByte(8'h00, r0);
      chk("R4 R5 R6 R7 R3 R9", $sformatf("vec%0d byte0", v), 16'(r0), 16'(e[19:12]));
      if (e[3:2] == 2'd2) begin
        xferByte(8'h00, r1);
        chk("R4 R5 R6 R3", $sformatf("vec%0d byte1", v), 16'(r1), 16'(e[11:4]));
      end
      frameClose();
      chk("R9", "miso idle after frame", 16'(miso), 16'h0);
    end
    chk("R2", "miso moved while sclk high", 16'(highMoves), 16'h0);

    // R8 snapshot
    curSample = 10'h1AB;
    frameOpen();
    xferByte(8'h04, rc);
    curSample = 10'h0CD;
    xferByte(8'h00, r0);
    xferByte(8'h00, r1);
    frameClose();
    chk("R8", "snapshot upper", 16'(r0), 16'h01);
    chk("R8", "snapshot lower", 16'(r1), 16'hAB);

    // R10 strobes
    s0 = shutHigh; o0 = onHigh;
    frameOpen(); xferByte(8'h02, rc); frameClose();
    chk("R10", "shutdown pulse cycles", 16'(shutHigh - s0), 16'd1);
    chk("R10", "no turn-on on shutdown", 16'(onHigh - o0), 16'd0);
    frameOpen(); xferByte(8'h03, rc); frameClose();
    chk("R10", "turn-on pulse cycles", 16'(onHigh - o0), 16'd1);
    chk("R10", "shutdown unchanged", 16'(shutHigh - s0), 16'd1);

    // R11 partial byte discarded
    s0 = shutHigh;
    frameOpen();
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b0; mosi = (i == 6); waitClk(HALF); sclk = 1'b1; waitClk(HALF);
    end
    frameClose();
    chk("R11", "partial 0x02 gave no strobe", 16'(shutHigh - s0), 16'd0);
    vinSample = 10'h2C3;
    frameOpen();
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; mosi = ~i[0]; waitClk(HALF); sclk = 1'b1; waitClk(HALF);
    end
    frameClose();
    frameOpen();
    xferByte(8'h05, rc); xferByte(8'h00, r0); xferByte(8'h00, r1);
    frameClose();
    chk("R11", "read after partial upper", 16'(r0), 16'h02);
    chk("R11", "read after partial lower", 16'(r1), 16'hC3);

    // R12 long gaps, R13 chained commands in one frame
    curSample = 10'h155; pwmDuty = 9'h13C; s0 = shutHigh;
    frameOpen();
    xferByte(8'h04, rc); waitClk(60);
    xferByte(8'h00, r0); waitClk(90);
    xferByte(8'h00, r1);
    chk("R12", "gapped upper", 16'(r0), 16'h01);
    chk("R12", "gapped lower", 16'(r1), 16'h55);
    xferByte(8'h06, rc);
    chk("R13", "second command byte miso", 16'(rc), 16'h0);
    xferByte(8'h00, r0); xferByte(8'h00, r1);
    chk("R13", "chained upper", 16'(r0), 16'h01);
    chk("R13", "chained lower", 16'(r1), 16'h3C);
    xferByte(8'h02, rc);
    frameClose();
    chk("R13", "chained shutdown", 16'(shutHigh - s0), 16'd1);
    chk("R2", "miso moved while sclk high (end)", 16'(highMoves), 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule